// File: doc/BRIEF.md
# Running-Sum Concentrator Address Generator

This block sits in front of a packing concentrator that has N inputs. Each input lane carries one activity bit, which is 1 when that lane holds a packet in the current slot. For every lane the block works out how many active lanes sit at lower indices. That count is the output port the lane's packet will take on the concentrator. Active packets therefore land on consecutive outputs starting at 0, and no two of them are given the same output. The concentrator's routing fabric can use these addresses directly.

The count is built by a parallel prefix network of log2(N) registered adder stages. No central controller walks the lanes one at a time. A concentrator with only R outputs cannot take every packet, so each lane also gets a pass flag. The flag is set only when the lane is active and its address is below R. Lanes whose flag is clear have been knocked out. The block also reports the number of active lanes in the slot. A valid bit travels with each slot through the pipeline. Lane 0 counts as the first lane.

Top module: `running_sum_addr_gen`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly log2(N) clock cycles (3 cycles for the default N=8), and a new slot can be accepted on every cycle.
- R2: For an active lane i, the address output in bits [i*log2(N) +: log2(N)] of `addr` equals the number of 1s in `act[i-1:0]`. The lowest-indexed active lane therefore gets address 0.
- R3: Among the lanes whose pass flag is set, the addresses run 0, 1, 2, … in increasing lane order, with no repeats and no gaps.
- R4: `addr_ok[i]` is 1 exactly when `act[i]` was 1 and the lane's address is less than R. An active lane whose address is R or more is knocked out and has `addr_ok[i]` = 0.
- R5: `total` equals the number of 1s in the activity vector of the slot being presented. The number of set bits of `addr_ok` equals the smaller of `total` and R.
- R6: An inactive lane presents address 0 and `addr_ok` = 0.
- R7: While reset is asserted, and after it is released until the first slot emerges, `out_valid` is 0 and `addr`, `addr_ok` and `total` are all 0.
- R8: While `out_valid` is 0, `addr`, `addr_ok` and `total` hold the values of the last slot that was presented. `act` sampled with `in_valid` = 0 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release it synchronously to `clk` |
| in_valid | input | 1 | `act` holds a slot to be processed |
| act | input | N | Activity bit per lane; 1 = packet present |
| out_valid | output | 1 | Outputs hold the result of a slot |
| addr | output | N*log2(N) | Concentrator address per lane, lane i in bits [i*log2(N) +: log2(N)] |
| addr_ok | output | N | Per-lane pass flag (active and address < R) |
| total | output | log2(N+1) | Number of active lanes in the slot |

## Verification
The bench drives edge patterns chosen to expose common faults:
- All lanes idle and all lanes busy. A network that forgets to subtract the lane's own bit gives lane 0 address 1 and shifts every lane up by one.
- A single packet on the top lane, and alternating patterns. A prefix stage with the wrong reach drops or double-counts some lanes.
- Exactly R and R+1 active lanes. An off-by-one in the knockout compare either passes the packet numbered R or drops the one numbered R-1.
- Bubbles carrying junk activity, followed by random traffic. Here a design that loads data without the valid enable, or misaligns the valid pipeline, changes the held outputs or flags the wrong cycle.

// File: rtl/cag_pkg.sv
package cag_pkg;

  // Number of prefix stages for an n-lane network.
  function automatic int stage_count(input int n);
    return $clog2(n);
  endfunction

  // Width of a running sum able to hold the value n.
  function automatic int sum_width(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/cag_prefix_stage.sv
// One registered level of the parallel running-sum network: every lane at
// index DIST or above adds the partial sum held DIST lanes below it.
module cag_prefix_stage #(
  parameter int N    = 8,
  parameter int SW   = 4,
  parameter int DIST = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            v_in,
  input  logic [N-1:0]    act_in,
  input  logic [N*SW-1:0] sum_in,
  output logic            v_out,
  output logic [N-1:0]    act_out,
  output logic [N*SW-1:0] sum_out
);

  logic [N*SW-1:0] sum_nx;
  logic            ld_en;

  assign ld_en = v_in;

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (i >= DIST) begin : g_add
      always_comb begin
        sum_nx[i*SW +: SW] = sum_in[i*SW +: SW] + sum_in[(i-DIST)*SW +: SW];
      end
    end else begin : g_pass
      always_comb begin
        sum_nx[i*SW +: SW] = sum_in[i*SW +: SW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out <= 1'b0;
    end else begin
      v_out <= v_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_out <= '0;
      sum_out <= '0;
    end else if (ld_en) begin
      act_out <= act_in;
      sum_out <= sum_nx;
    end
  end

endmodule

// File: rtl/cag_knockout.sv
// Turns inclusive running sums into exclusive addresses, applies the
// R-output knockout limit and extracts the slot's active count.
module cag_knockout #(
  parameter int N  = 8,
  parameter int R  = 4,
  parameter int SW = 4,
  parameter int AW = 3
) (
  input  logic [N-1:0]    act,
  input  logic [N*SW-1:0] incl,
  output logic [N*AW-1:0] addr,
  output logic [N-1:0]    addr_ok,
  output logic [SW-1:0]   total
);

  localparam logic [SW-1:0] LIMIT = SW'(R);

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [SW-1:0] inc_sum;
    logic [SW-1:0] exc_sum;

    assign inc_sum = incl[g*SW +: SW];
    assign exc_sum = inc_sum - SW'(act[g]);

    always_comb begin
      if (act[g]) begin
        addr[g*AW +: AW] = exc_sum[AW-1:0];
        addr_ok[g]       = (exc_sum < LIMIT);
      end else begin
        addr[g*AW +: AW] = '0;
        addr_ok[g]       = 1'b0;
      end
    end
  end

  assign total = incl[(N-1)*SW +: SW];

endmodule

// File: rtl/running_sum_addr_gen.sv
module running_sum_addr_gen #(
  parameter int N = 8,
  parameter int R = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [N-1:0]              act,
  output logic                      out_valid,
  output logic [N*$clog2(N)-1:0]    addr,
  output logic [N-1:0]              addr_ok,
  output logic [$clog2(N+1)-1:0]    total
);

  localparam int LOG = cag_pkg::stage_count(N);
  localparam int SW  = cag_pkg::sum_width(N);
  localparam int AW  = LOG;

  logic            v_c   [0:LOG];
  logic [N-1:0]    act_c [0:LOG];
  logic [N*SW-1:0] sum_c [0:LOG];

  assign v_c[0]   = in_valid;
  assign act_c[0] = act;

  for (genvar i = 0; i < N; i++) begin : g_seed
    assign sum_c[0][i*SW +: SW] = SW'(act[i]);
  end

  for (genvar k = 0; k < LOG; k++) begin : g_stage
    cag_prefix_stage #(
      .N   (N),
      .SW  (SW),
      .DIST(1 << k)
    ) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .v_in   (v_c[k]),
      .act_in (act_c[k]),
      .sum_in (sum_c[k]),
      .v_out  (v_c[k+1]),
      .act_out(act_c[k+1]),
      .sum_out(sum_c[k+1])
    );
  end

  cag_knockout #(
    .N (N),
    .R (R),
    .SW(SW),
    .AW(AW)
  ) u_knockout (
    .act    (act_c[LOG]),
    .incl   (sum_c[LOG]),
    .addr   (addr),
    .addr_ok(addr_ok),
    .total  (total)
  );

  assign out_valid = v_c[LOG];

endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int N = 8,
  parameter int R = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   out_valid,
  input logic [N*$clog2(N)-1:0] addr,
  input logic [N-1:0]           addr_ok,
  input logic [$clog2(N+1)-1:0] total
);

  localparam int AW  = $clog2(N);
  localparam int CW  = $clog2(N+1);
  localparam int LOG = $clog2(N);
  localparam logic [CW-1:0] LIM = CW'(R);

  logic vshadow [0:LOG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LOG; k++) vshadow[k] <= 1'b0;
    end else begin
      vshadow[0] <= in_valid;
      for (int k = 1; k < LOG; k++) vshadow[k] <= vshadow[k-1];
    end
  end

  // R1: valid emerges log2(N) cycles after it enters
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vshadow[LOG-1]);

  // R5: pass flags count min(total, R)
  p_pass_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(addr_ok) == ((total < LIM) ? int'(total) : R)));

  // R8: outputs hold while no slot is presented
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(addr) && $stable(addr_ok) && $stable(total)));

  for (genvar i = 0; i < N; i++) begin : g_lane
    // R4: a passing lane has an address below R
    p_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ok[i] |-> (int'(addr[i*AW +: AW]) < R));

    for (genvar j = i + 1; j < N; j++) begin : g_pair
      // R3: passing lanes get strictly increasing addresses
      p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_ok[i] && addr_ok[j]) |-> (addr[i*AW +: AW] < addr[j*AW +: AW]));
    end
  end

endmodule

bind running_sum_addr_gen cag_checker #(.N(N), .R(R)) u_cag_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .addr     (addr),
  .addr_ok  (addr_ok),
  .total    (total)
);

// File: tb/running_sum_addr_gen_bench.sv
`timescale 1ns/1ps
module running_sum_addr_gen_bench;

  localparam int N   = 8;
  localparam int R   = 4;
  localparam int AW  = $clog2(N);
  localparam int CW  = $clog2(N+1);
  localparam int LOG = $clog2(N);

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic [N-1:0]        act;
  logic                out_valid;
  logic [N*AW-1:0]     addr;
  logic [N-1:0]        addr_ok;
  logic [CW-1:0]       total;

  int n_chk;
  int n_bad;
  bit finished;

  running_sum_addr_gen #(.N(N), .R(R)) u_running_sum_addr_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .act      (act),
    .out_valid(out_valid),
    .addr     (addr),
    .addr_ok  (addr_ok),
    .total    (total)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural pipeline model: slots in flight, oldest at index LOG-1.
  logic         mv [0:LOG-1];
  logic [N-1:0] ma [0:LOG-1];
  logic [N-1:0] last_act;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LOG; k++) begin
        mv[k] <= 1'b0;
        ma[k] <= '0;
      end
    end else begin
      for (int k = LOG - 1; k > 0; k--) begin
        mv[k] <= mv[k-1];
        ma[k] <= ma[k-1];
      end
      mv[0] <= in_valid;
      ma[0] <= act;
    end
  end

  function automatic void ref_calc(input logic [N-1:0] a,
                                   output logic [N*AW-1:0] ea,
                                   output logic [N-1:0] eo,
                                   output logic [CW-1:0] et);
    int cnt;
    cnt = 0;
    ea = '0;
    eo = '0;
    for (int i = 0; i < N; i++) begin
      if (a[i]) begin
        ea[i*AW +: AW] = AW'(cnt);
        eo[i] = (cnt < R);
        cnt++;
      end
    end
    et = CW'(cnt);
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Compare every output with the model; called away from the active edge.
  task automatic compare_cycle();
    logic [N-1:0]    ea;
    logic [N*AW-1:0] e_addr;
    logic [N-1:0]    e_ok;
    logic [CW-1:0]   e_tot;
    int              seen;
    bit              held;
    held = !mv[LOG-1];
    ea   = held ? last_act : ma[LOG-1];
    ref_calc(ea, e_addr, e_ok, e_tot);
    chk("R1 out_valid", 64'(out_valid), 64'(mv[LOG-1]));
    chk(held ? "R8 held addr" : "R2 addr", 64'(addr), 64'(e_addr));
    chk(held ? "R8 held addr_ok" : "R4 addr_ok", 64'(addr_ok), 64'(e_ok));
    chk(held ? "R8 held total" : "R5 total", 64'(total), 64'(e_tot));
    for (int i = 0; i < N; i++) begin
      if (!ea[i]) begin
        chk("R6 idle lane", {addr_ok[i], 63'(addr[i*AW +: AW])}, 64'd0);
      end
    end
    seen = 0;
    for (int i = 0; i < N; i++) begin
      if (addr_ok[i]) begin
        chk("R3 contiguous pass address", 64'(addr[i*AW +: AW]), 64'(seen));
        seen++;
      end
    end
    if (!held) last_act = ma[LOG-1];
  endtask

  task automatic step(input logic v, input logic [N-1:0] a);
    @(negedge clk);
    compare_cycle();
    in_valid = v;
    act      = a;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat [0:9];
    n_chk    = 0;
    n_bad    = 0;
    finished = 0;
    last_act = '0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    act      = 8'hFF;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R7 outputs in reset", {48'd0, 8'(total), addr_ok}, 64'd0);
    chk("R7 addr in reset", 64'(addr), 64'd0);
    rst_n = 1'b1;
    act   = '0;
    repeat (LOG + 1) step(1'b0, 8'hA5);   // R8: junk with valid low

    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'hAA; pat[3] = 8'h55;
    pat[4] = 8'h80; pat[5] = 8'h01; pat[6] = 8'h0F; pat[7] = 8'hF0;
    pat[8] = 8'h1F; pat[9] = 8'h07;
    for (int p = 0; p < 10; p++) step(1'b1, pat[p]);
    repeat (LOG + 2) step(1'b0, 8'hFF);   // R8: bubbles hold the last slot
    for (int p = 0; p < 10; p++) begin
      step(1'b1, pat[9 - p]);
      step(1'b0, ~pat[p]);
    end
    for (int c = 0; c < 400; c++) begin
      step(($urandom % 4) != 0, N'($urandom));
    end
    repeat (LOG + 2) step(1'b0, '0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule